// File: doc/BRIEF.md
# Hibernate Wake Filter and Reset Sequencer

This block lives in the always-on power domain and runs from the slow timekeeping clock. Each clock cycle counts as one tick. Software enters hibernation by writing a command register. The block then drops its power-enable output and holds the system reset asserted.

While hibernating, the block watches an active-low wake pin. The pin passes through a two-stage synchronizer and then a debounce counter, so a short glitch cannot power the chip back up. When a wake is accepted, power-enable rises and the active-low system reset stays asserted for a programmed number of ticks. The reset is then released.

Both durations come from register fields whose five lowest bits are always zero. This gives a resolution of 32 ticks. At a 32.768 kHz tick, the filter spans roughly two seconds and the reset pulse roughly 125 ms. Driver code derives a field as duration_ms × rate / 1000, clipped to the field mask. A write interface sets the values and a combinational read port returns them.

Top module: `wr_seq_top`

## Requirements
- R1: While `rst_ni` is low, `pwr_en_o` is 1 and `sys_rst_no` is 0. The filter field reads 0x07A0 and the reset field reads 0x0CC0. After `rst_ni` rises, `sys_rst_no` goes high on exactly the 3265th clock edge, and `pwr_en_o` stays high throughout.
- R2: Register offsets are as follows. 0x20 is the hibernate command, which always reads 0. 0x24 is the wake filter field, which keeps only data bits 15:5. 0x28 is the reset length field, which keeps only bits 11:5. All other bits are stored as 0, and any unmapped offset reads 0.
- R3: In the running state, a write to 0x20 with data bit 0 set clears `pwr_en_o` and `sys_rst_no` at that clock edge. A write with bit 0 clear has no effect. Power-enable falls for no other reason.
- R4: A hibernate write during the post-wake or power-on reset hold is ignored. The hold length is unchanged and `pwr_en_o` stays high.
- R5: While hibernating, a low pulse on `wake_ni` that spans N clock edges wakes the block if and only if N ≥ F + 2, where F is the stored filter value.
- R6: If the synchronized pin deasserts before the filter count completes, the block returns to hibernation with its count cleared. A later pulse is timed from zero.
- R7: When a wake is accepted, `pwr_en_o` rises on the (F + 4)th clock edge, counting the first edge at which `wake_ni` is low.
- R8: After `pwr_en_o` rises, `sys_rst_no` stays low for R + 1 clock edges and then rises, where R is the stored reset value. `wake_ni` has no effect during the reset hold or in the running state.
- R9: A filter or reset field of 0 makes the corresponding phase last a single tick.
- R10: Whenever `pwr_en_o` is 0, `sys_rst_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wake_ni | input | 1 | Asynchronous active-low wake pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 6 | Register read offset |
| rd_data_o | output | 16 | Register read data, combinational |
| pwr_en_o | output | 1 | Power-enable for the switched domain |
| sys_rst_no | output | 1 | Active-low system reset |

## Verification
The assertions check on every cycle that reset is asserted whenever power is off, and that power falls only after a hibernate command. They also check that reset is held when power comes up, that a running system leaves that state only on command, and that every register readback has its ignored bits at zero. The exact tick counts can only be seen in the bench scenarios. These cover the filter acceptance boundary at F + 1 versus F + 2, the counter clearing across a one-cycle gap, the power-up and reset-release latencies across several field values including zero and the saturated maximum, and commands that arrive during a reset hold.

// File: rtl/wr_seq_pkg.sv
package wr_seq_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_HIB  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_FILT = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_RST  = 6'h28;

  // bit 2 drives power enable, bit 1 drives reset release
  typedef enum logic [2:0] {
    ST_HIBER   = 3'b000,
    ST_FILTER  = 3'b001,
    ST_RSTHOLD = 3'b100,
    ST_ACTIVE  = 3'b110
  } seq_state_e;

  function automatic logic [DATA_W-1:0] field_mask(input int msb, input int lsb);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= msb) && (i >= lsb);
    return m;
  endfunction
endpackage

// File: rtl/wr_seq_regs.sv
module wr_seq_regs
  import wr_seq_pkg::*;
#(
  parameter int                FIELD_LSB = 5,
  parameter int                FILT_MSB  = 15,
  parameter int                RST_MSB   = 11,
  parameter logic [DATA_W-1:0] FILT_DEF  = 16'h07A0,
  parameter logic [DATA_W-1:0] RST_DEF   = 16'h0CC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] filt_lim_o,
  output logic [DATA_W-1:0] rst_lim_o,
  output logic              hib_req_o
);
  localparam logic [DATA_W-1:0] FILT_MASK = field_mask(FILT_MSB, FIELD_LSB);
  localparam logic [DATA_W-1:0] RST_MASK  = field_mask(RST_MSB, FIELD_LSB);

  logic [DATA_W-1:0] filt_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= FILT_DEF & FILT_MASK;
      rst_q  <= RST_DEF & RST_MASK;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFS_FILT) filt_q <= wr_data_i & FILT_MASK;
      if (wr_addr_i == OFS_RST)  rst_q  <= wr_data_i & RST_MASK;
    end
  end

  assign hib_req_o  = wr_en_i && (wr_addr_i == OFS_HIB) && wr_data_i[0];
  assign filt_lim_o = filt_q;
  assign rst_lim_o  = rst_q;

  always_comb begin
    case (rd_addr_i)
      OFS_FILT: rd_data_o = filt_q;
      OFS_RST:  rd_data_o = rst_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wr_seq_sync.sv
module wr_seq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RESET_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RESET_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wr_seq_cnt.sv
module wr_seq_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // cleared whenever its phase is not active, so each entry starts at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (!done_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q >= lim_i);
endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
  import wr_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_act_i,
  input  logic hib_req_i,
  input  logic filt_done_i,
  input  logic rst_done_i,
  output logic filt_run_o,
  output logic rst_run_o,
  output logic pwr_en_o,
  output logic sys_rst_no
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (hib_req_i) state_d = ST_HIBER;
      ST_HIBER:   if (pin_act_i) state_d = ST_FILTER;
      ST_FILTER: begin
        if (!pin_act_i)       state_d = ST_HIBER;
        else if (filt_done_i) state_d = ST_RSTHOLD;
      end
      ST_RSTHOLD: if (rst_done_i) state_d = ST_ACTIVE;
      default:    state_d = ST_RSTHOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RSTHOLD;
    else         state_q <= state_d;
  end

  assign filt_run_o = (state_q == ST_FILTER);
  assign rst_run_o  = (state_q == ST_RSTHOLD);
  assign pwr_en_o   = state_q[2];
  assign sys_rst_no = state_q[1];
endmodule

// File: rtl/wr_seq_top.sv
module wr_seq_top
  import wr_seq_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                FIELD_LSB   = 5,
  parameter int                FILT_MSB    = 15,
  parameter int                RST_MSB     = 11,
  parameter logic [DATA_W-1:0] FILT_DEF    = 16'h07A0,
  parameter logic [DATA_W-1:0] RST_DEF     = 16'h0CC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pwr_en_o,
  output logic              sys_rst_no
);
  logic [DATA_W-1:0] filt_lim, rst_lim;
  logic hib_req, wake_sync_n, filt_run, rst_run, filt_done, rst_done;

  wr_seq_regs #(
    .FIELD_LSB(FIELD_LSB), .FILT_MSB(FILT_MSB), .RST_MSB(RST_MSB),
    .FILT_DEF(FILT_DEF), .RST_DEF(RST_DEF)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .filt_lim_o(filt_lim), .rst_lim_o(rst_lim), .hib_req_o(hib_req)
  );

  wr_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(wake_ni), .q_o(wake_sync_n)
  );

  wr_seq_cnt #(.W(DATA_W)) u_filt_cnt (
    .clk_i, .rst_ni, .run_i(filt_run), .lim_i(filt_lim), .done_o(filt_done)
  );

  wr_seq_cnt #(.W(DATA_W)) u_rst_cnt (
    .clk_i, .rst_ni, .run_i(rst_run), .lim_i(rst_lim), .done_o(rst_done)
  );

  wr_seq_fsm u_fsm (
    .clk_i, .rst_ni, .pin_act_i(!wake_sync_n), .hib_req_i(hib_req),
    .filt_done_i(filt_done), .rst_done_i(rst_done),
    .filt_run_o(filt_run), .rst_run_o(rst_run),
    .pwr_en_o, .sys_rst_no
  );
endmodule

// File: rtl/wr_seq_chk.sv
module wr_seq_chk
  import wr_seq_pkg::*;
#(
  parameter int FIELD_LSB = 5,
  parameter int FILT_MSB  = 15,
  parameter int RST_MSB   = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              pwr_en_o,
  input logic              sys_rst_no
);
  localparam logic [DATA_W-1:0] FILT_MASK = field_mask(FILT_MSB, FIELD_LSB);
  localparam logic [DATA_W-1:0] RST_MASK  = field_mask(RST_MSB, FIELD_LSB);

  logic hib_cmd;
  assign hib_cmd = wr_en_i && (wr_addr_i == OFS_HIB) && wr_data_i[0];

  a_r10_reset_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !sys_rst_no);

  a_r3_drop_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(hib_cmd));

  a_r8_reset_at_powerup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> !sys_rst_no);

  a_r8_release_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (pwr_en_o && $past(pwr_en_o)));

  a_r3_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && !hib_cmd) |=> sys_rst_no);

  a_r2_filt_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == OFS_FILT) |-> ((rd_data_o & ~FILT_MASK) == '0));

  a_r2_rst_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == OFS_RST) |-> ((rd_data_o & ~RST_MASK) == '0));

  a_r2_hib_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == OFS_HIB) |-> (rd_data_o == '0));
endmodule

bind wr_seq_top wr_seq_chk #(
  .FIELD_LSB(FIELD_LSB), .FILT_MSB(FILT_MSB), .RST_MSB(RST_MSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .pwr_en_o(pwr_en_o), .sys_rst_no(sys_rst_no)
);

// File: tb/tb_wr_seq_top.sv
`timescale 1ns/1ps
module tb_wr_seq_top;
  localparam logic [5:0]  A_HIB  = 6'h20;
  localparam logic [5:0]  A_FILT = 6'h24;
  localparam logic [5:0]  A_RST  = 6'h28;
  localparam logic [15:0] M_FILT = 16'hFFE0;
  localparam logic [15:0] M_RST  = 16'h0FE0;
  localparam int          POR_HOLD = 16'h0CC0 + 1;

  // {filter write, reset write}
  localparam logic [31:0] VEC [6] = '{
    32'h0000_0000, 32'h001F_001F, 32'h0020_003F,
    32'h0045_1060, 32'hFFFF_FFFF, 32'h00A0_F020
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wake_ni = 1'b1;
  logic wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [5:0] rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic pwr_en_o, sys_rst_no;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wr_seq_top dut (
    .clk_i(clk), .rst_ni, .wake_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .pwr_en_o, .sys_rst_no
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    rd_addr_i = a; #1; v = rd_data_o;
  endtask

  task automatic wait_rise(input bit on_rst, output int c);
    c = 0;
    do begin
      @(posedge clk); @(negedge clk); c++;
    end while (((on_rst ? sys_rst_no : pwr_en_o) == 1'b0) && c < 80000);
  endtask

  initial begin
    int v, c;
    bit pw_ok;
    #20;
    chk("R1", "pwr in reset", pwr_en_o, 1);
    chk("R1", "rst in reset", sys_rst_no, 0);
    rd(A_FILT, v); chk("R1", "filter default", v, 16'h07A0);
    rd(A_RST, v);  chk("R1", "reset default", v, 16'h0CC0);
    @(negedge clk); rst_ni = 1'b1;
    // R4: hibernate command mid-hold is ignored
    c = 0; pw_ok = 1;
    do begin
      if (c == 10) begin wr_en_i = 1'b1; wr_addr_i = A_HIB; wr_data_i = 16'h0001; end
      @(posedge clk); @(negedge clk);
      wr_en_i = 1'b0; c++;
      if (!pwr_en_o) pw_ok = 0;
    end while (!sys_rst_no && c < 5000);
    chk("R1", "power-on hold edges", c, POR_HOLD);
    chk("R4", "pwr kept during hold", pw_ok, 1);

    wr(A_HIB, 16'hFFFE);
    chk("R3", "bit0 clear keeps pwr", pwr_en_o, 1);
    chk("R3", "bit0 clear keeps rst", sys_rst_no, 1);
    rd(A_HIB, v);    chk("R2", "hib reads zero", v, 0);
    rd(6'h30, v);    chk("R2", "unmapped reads zero", v, 0);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] f, r;
      int ef, er;
      f = VEC[i][31:16]; r = VEC[i][15:0];
      ef = int'(f & M_FILT); er = int'(r & M_RST);
      wr(A_FILT, f); wr(A_RST, r);
      rd(A_FILT, v); chk("R2", "filter readback", v, ef);
      rd(A_RST, v);  chk("R2", "reset readback", v, er);
      wr(A_HIB, 16'h0001);
      chk("R3", "pwr drops", pwr_en_o, 0);
      chk("R10", "rst low while off", sys_rst_no, 0);
      wake_ni = 1'b0;
      wait_rise(0, c);
      chk((ef == 0) ? "R9" : "R7", "edges to power up", c, ef + 4);
      chk("R8", "rst low at power up", sys_rst_no, 0);
      wait_rise(1, c);
      chk((er == 0) ? "R9" : "R8", "reset hold edges", c, er + 1);
      wake_ni = 1'b1;
    end

    // R8: pin activity while running is ignored
    wake_ni = 1'b0;
    repeat (5) @(negedge clk);
    wake_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "pin ignored pwr", pwr_en_o, 1);
    chk("R8", "pin ignored rst", sys_rst_no, 1);

    // filter boundary with F = 64
    wr(A_FILT, 16'h0040); wr(A_RST, 16'h0000);
    wr(A_HIB, 16'h0001);
    wake_ni = 1'b0; repeat (65) @(negedge clk); wake_ni = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5", "F+1 pulse rejected", pwr_en_o, 0);
    wake_ni = 1'b0; repeat (65) @(negedge clk); wake_ni = 1'b1;
    @(negedge clk);
    wake_ni = 1'b0; repeat (65) @(negedge clk); wake_ni = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6", "count cleared on gap", pwr_en_o, 0);
    wake_ni = 1'b0; repeat (66) @(negedge clk); wake_ni = 1'b1;
    wait_rise(0, c);
    chk("R5", "F+2 pulse accepted", c, 2);
    wait_rise(1, c);
    chk("R9", "zero reset field", c, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule